// File: doc/BRIEF.md
# Variable-Width Stack Push/Pull Unit

This unit moves a data word between a register-side value and a byte-addressed stack in memory, one byte per clock. A caller presents an operation (push or pull), a size value, a 64-bit word to push, the current 16-bit stack pointer and a stack-page base. The unit then walks the stack pointer through the bytes and drives a byte-wide memory port. When the transfer ends it reports the updated stack pointer and, for a pull, the assembled word.

Every stack access goes to the page base placed above the 16-bit pointer, so the pointer wraps inside its page and never reaches the page. A push stores the highest selected byte first and steps the pointer down after each byte. A pull steps the pointer up before each read and fills the word from byte 0 upward. The unit does not choose which architectural register is pushed or written back; it moves a data word only.

Top module: `stack_byte_mover`

## Requirements
- R1: Each access goes to address {pageBase, P}, where the page sits in bits 23:16 and P is the 16-bit pointer. A push uses the current pointer. A pull uses the pointer plus one (pre-increment).
- R2: The byte count N comes from the 4-bit reqSize. A value of 0 gives N=1, values 1 to 8 give N equal to the value, and values 9 to 15 give N=8.
- R3: A push writes byte N-1 of pushData (bits 8k+7:8k form byte k) in its first busy cycle and works down to byte 0. The pointer falls by one after each byte, so spOut equals spIn minus N when done.
- R4: A pull reads byte 0 first and continues upward. memRdata is captured in the same cycle that memRe is high (the read is combinational). spOut equals spIn plus N when done.
- R5: In pullData, bytes N and above are zero. pullData and spOut hold their final values from the done cycle until the next accepted request.
- R6: A request is accepted when reqValid is high and busy is low. busy is then high for exactly N consecutive cycles, starting with the cycle after acceptance. done is a one-cycle pulse in the cycle after the last byte, with busy low.
- R7: The pointer wraps modulo 2^16 and never carries into or borrows from the page bits, which stay constant during an operation.
- R8: A reqValid seen while busy is high is ignored. The running transfer is unchanged, and no second transfer follows it.
- R9: After reset, busy, done, memWe and memRe are low, and spOut and pullData are zero.
- R10: In every busy cycle exactly one strobe is high: memWe for a push, memRe for a pull. Both are low when the unit is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqPull | input | 1 | 1 = pull, 0 = push |
| reqSize | input | 4 | Size value, clamped to 1..8 bytes |
| pushData | input | 64 | Word to push |
| spIn | input | 16 | Stack pointer at request time |
| pageBase | input | 8 | Stack page, placed above the pointer |
| memAddr | output | 24 | Byte address |
| memWe | output | 1 | Byte write strobe |
| memWdata | output | 8 | Byte to write |
| memRe | output | 1 | Byte read strobe |
| memRdata | input | 8 | Byte read, valid in the same cycle as memRe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pullData | output | 64 | Assembled pulled word |
| spOut | output | 16 | Updated stack pointer |

## Verification
The assertions check on every cycle that at most one strobe is active and that the strobes match busy. They also check that successive addresses step down for pushes and up for pulls, that the page bits never move during a run, and that done only follows busy. A run is never allowed to exceed eight cycles. Only the bench's sweeps can show the remaining behaviour: the exact byte order and content, the size clamping, the zeroed upper bytes, the final pointer value across the wrap points, and that a request arriving mid-transfer leaves no trace.

// File: rtl/stack_byte_mover_pkg.sv
package stack_byte_mover_pkg;
  typedef struct packed {
    logic load;    // latch a new request
    logic step;    // move one byte this cycle
    logic isPull;  // direction of the running transfer
  } moverStrobes_t;
endpackage

// File: rtl/stack_byte_mover_ctrl.sv
module stack_byte_mover_ctrl
  import stack_byte_mover_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int SIZE_W     = 4,
  localparam int IDX_W     = $clog2(DATA_BYTES),
  localparam int CNT_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPull,
  input  logic [SIZE_W-1:0] reqSize,
  output moverStrobes_t     strb,
  output logic [IDX_W-1:0]  byteIdx,
  output logic              busy,
  output logic              done
);
  logic             busyQ, doneQ, pullQ;
  logic [CNT_W-1:0] remQ;
  logic [IDX_W-1:0] idxQ;
  logic [CNT_W-1:0] reqCount;
  logic             accept;

  // clamp the size value into 1..DATA_BYTES
  always_comb begin
    if (reqSize == '0)
      reqCount = CNT_W'(1);
    else if (int'(reqSize) > DATA_BYTES)
      reqCount = CNT_W'(DATA_BYTES);
    else
      reqCount = CNT_W'(reqSize);
  end

  assign accept = reqValid && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      pullQ <= 1'b0;
      remQ  <= '0;
      idxQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ <= 1'b1;
        pullQ <= reqPull;
        remQ  <= reqCount;
        idxQ  <= reqPull ? '0 : IDX_W'(reqCount - CNT_W'(1));
      end else if (busyQ) begin
        if (remQ == CNT_W'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
        remQ <= remQ - CNT_W'(1);
        idxQ <= pullQ ? idxQ + IDX_W'(1) : idxQ - IDX_W'(1);
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.step   = busyQ;
    strb.isPull = pullQ;
  end

  assign byteIdx = idxQ;
  assign busy    = busyQ;
  assign done    = doneQ;
endmodule

// File: rtl/stack_byte_mover_dp.sv
module stack_byte_mover_dp
  import stack_byte_mover_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int SP_W       = 16,
  parameter int PAGE_W     = 8,
  localparam int IDX_W     = $clog2(DATA_BYTES),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int ADDR_W    = PAGE_W + SP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  moverStrobes_t     strb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [DATA_W-1:0] pushData,
  input  logic [SP_W-1:0]   spIn,
  input  logic [PAGE_W-1:0] pageBase,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [7:0]        memWdata,
  output logic [DATA_W-1:0] pullData,
  output logic [SP_W-1:0]   spOut
);
  logic [SP_W-1:0]   spQ;
  logic [PAGE_W-1:0] pageQ;
  logic [DATA_W-1:0] dataQ;
  logic [SP_W-1:0]   accessSp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ   <= '0;
      pageQ <= '0;
      dataQ <= '0;
    end else if (strb.load) begin
      spQ   <= spIn;
      pageQ <= pageBase;
      dataQ <= pushData;
    end else if (strb.step) begin
      spQ <= strb.isPull ? spQ + SP_W'(1) : spQ - SP_W'(1);
    end
  end

  // pull pre-increments, push uses the pointer as is; page kept apart
  assign accessSp = strb.isPull ? spQ + SP_W'(1) : spQ;
  assign memAddr  = {pageQ, accessSp};
  assign memWe    = strb.step && !strb.isPull;
  assign memRe    = strb.step && strb.isPull;
  assign memWdata = dataQ[byteIdx*8 +: 8];

  // one capture register per byte lane of the pulled word
  for (genvar lane = 0; lane < DATA_BYTES; lane++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        laneQ <= '0;
      else if (strb.load)
        laneQ <= '0;
      else if (memRe && byteIdx == IDX_W'(lane))
        laneQ <= memRdata;
    end
    assign pullData[lane*8 +: 8] = laneQ;
  end

  assign spOut = spQ;
endmodule

// File: rtl/stack_byte_mover.sv
module stack_byte_mover
  import stack_byte_mover_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int SP_W       = 16,
  parameter int PAGE_W     = 8,
  parameter int SIZE_W     = 4,
  localparam int IDX_W     = $clog2(DATA_BYTES),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int ADDR_W    = PAGE_W + SP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPull,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] pushData,
  input  logic [SP_W-1:0]   spIn,
  input  logic [PAGE_W-1:0] pageBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              memRe,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] pullData,
  output logic [SP_W-1:0]   spOut
);
  moverStrobes_t    strb;
  logic [IDX_W-1:0] byteIdx;

  stack_byte_mover_ctrl #(
    .DATA_BYTES(DATA_BYTES),
    .SIZE_W    (SIZE_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqPull (reqPull),
    .reqSize (reqSize),
    .strb    (strb),
    .byteIdx (byteIdx),
    .busy    (busy),
    .done    (done)
  );

  stack_byte_mover_dp #(
    .DATA_BYTES(DATA_BYTES),
    .SP_W      (SP_W),
    .PAGE_W    (PAGE_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .byteIdx (byteIdx),
    .pushData(pushData),
    .spIn    (spIn),
    .pageBase(pageBase),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWe   (memWe),
    .memRe   (memRe),
    .memWdata(memWdata),
    .pullData(pullData),
    .spOut   (spOut)
  );
endmodule

// File: rtl/stack_byte_mover_chk.sv
module stack_byte_mover_chk #(
  parameter int DATA_BYTES = 8,
  parameter int SP_W       = 16,
  parameter int PAGE_W     = 8,
  localparam int ADDR_W    = PAGE_W + SP_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              memRe,
  input logic              busy,
  input logic              done
);
  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 8'd1;
    else           runLen <= '0;
  end

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));
  a_r10_busy_moves: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (memWe || memRe));
  a_r3_push_descends: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && memWe) |->
      memAddr[SP_W-1:0] == $past(memAddr[SP_W-1:0]) - SP_W'(1));
  a_r4_pull_ascends: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && memRe) |->
      memAddr[SP_W-1:0] == $past(memAddr[SP_W-1:0]) + SP_W'(1));
  a_r7_page_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr[ADDR_W-1:SP_W]));
  a_r8_direction_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memWe));
  a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rstN)
    int'(runLen) <= DATA_BYTES);
endmodule

bind stack_byte_mover stack_byte_mover_chk #(
  .DATA_BYTES(DATA_BYTES),
  .SP_W      (SP_W),
  .PAGE_W    (PAGE_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .memAddr(memAddr),
  .memWe  (memWe),
  .memRe  (memRe),
  .busy   (busy),
  .done   (done)
);

// File: tb/stack_byte_mover_tb_top.sv
module stack_byte_mover_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqPull = 1'b0;
  logic [3:0]  reqSize = '0;
  logic [63:0] pushData = '0;
  logic [15:0] spIn = '0;
  logic [7:0]  pageBase = '0;
  logic [23:0] memAddr;
  logic        memWe, memRe, busy, done;
  logic [7:0]  memWdata, memRdata;
  logic [63:0] pullData;
  logic [15:0] spOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // stack memory model: byte content derived from its address
  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction
  assign memRdata = memByte(memAddr);

  stack_byte_mover dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPull(reqPull),
    .reqSize(reqSize), .pushData(pushData), .spIn(spIn), .pageBase(pageBase),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRe(memRe),
    .memRdata(memRdata), .busy(busy), .done(done), .pullData(pullData),
    .spOut(spOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampN(input int sz);
    if (sz == 0) return 1;
    if (sz > 8) return 8;
    return sz;
  endfunction

  // one transfer; poke injects a conflicting request mid-run (R8)
  task automatic runOp(input bit pull, input int sz, input logic [63:0] data,
                       input logic [15:0] sp, input logic [7:0] page, input bit poke);
    int n;
    logic [63:0] expPull;
    n = clampN(sz);
    expPull = '0;
    @(negedge clk);
    reqValid = 1'b1; reqPull = pull; reqSize = 4'(sz);
    pushData = data; spIn = sp; pageBase = page;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] p;
      if (k > 0) @(negedge clk);
      if (poke && k == 2) reqValid = 1'b0;
      chk("R6 busy during transfer", 64'(busy), 64'd1);
      if (pull) begin
        p = sp + 16'(k + 1);
        chk("R1 R4 pull address", 64'(memAddr), 64'({page, p}));
        chk("R10 pull strobes", 64'({memRe, memWe}), 64'b10);
        expPull[k*8 +: 8] = memByte({page, p});
      end else begin
        p = sp - 16'(k);
        chk("R1 R3 push address", 64'(memAddr), 64'({page, p}));
        chk("R10 push strobes", 64'({memWe, memRe}), 64'b10);
        chk("R3 push byte order", 64'(memWdata), 64'(data[(n-1-k)*8 +: 8]));
      end
      if (poke && k == 1) begin
        reqValid = 1'b1; reqPull = ~pull; reqSize = 4'd1;
        spIn = 16'h1234; pageBase = 8'h77; pushData = '1;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 done pulse after last byte", 64'({done, busy}), 64'b10);
    if (pull) begin
      chk("R4 R7 final pointer after pull", 64'(spOut), 64'(16'(sp + 16'(n))));
      chk("R4 R5 pulled word", pullData, expPull);
    end else begin
      chk("R3 R7 final pointer after push", 64'(spOut), 64'(16'(sp - 16'(n))));
    end
    @(negedge clk);
    chk("R6 done is one cycle", 64'({done, busy}), 64'b00);
    if (poke) chk("R8 no second transfer", 64'({busy, memWe, memRe}), 64'b000);
    chk("R5 pointer held", 64'(spOut), pull ? 64'(16'(sp + 16'(n))) : 64'(16'(sp - 16'(n))));
    if (pull) chk("R5 pulled word held", pullData, expPull);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] sps [5];
    logic [7:0]  pages [2];
    sps[0] = 16'h0000; sps[1] = 16'h0005; sps[2] = 16'hFFFE;
    sps[3] = 16'hFFFF; sps[4] = 16'h8000;
    pages[0] = 8'h00; pages[1] = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R9 reset control", 64'({busy, done, memWe, memRe}), 64'b0000);
    chk("R9 reset pointer", 64'(spOut), 64'd0);
    chk("R9 reset pulled word", pullData, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'({busy, done, memWe, memRe}), 64'b0000);
    // sweep of direction, size value (R2 clamp), wrap points (R7), pages
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 16; s++)
        for (int i = 0; i < 5; i++)
          for (int g = 0; g < 2; g++)
            runOp(d[0], s, 64'h0123_4567_89AB_CDEF ^ (64'(s) * 64'h1111_0000_0101) ^ 64'(sps[i]),
                  sps[i], pages[g], 1'b0);
    // R8: request raised while busy, both directions
    runOp(1'b0, 8, 64'hFEDC_BA98_7654_3210, 16'h0002, 8'h3C, 1'b1);
    runOp(1'b1, 8, 64'h0, 16'hFFFC, 8'hC3, 1'b1);
    runOp(1'b1, 12, 64'h0, 16'h4000, 8'h01, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule